// File: doc/BRIEF.md
# Indirect Configuration Register Bank

This block holds a small set of configuration entries behind two bus locations. Location 0 is an index register and location 1 is a data window. Software writes an entry number into the index, then reads or writes the data window to reach that entry. Entry 0 holds a fixed revision constant. Entry 1 is a control word. Most of its bits behave differently from plain storage.

The control word drives these control levels:
- a test-mode flag that cannot be cleared once set;
- a self-programming enable, which the lock state guards;
- a lock indicator, which tracks an external unlock input;
- a clock-output disable;
- a freeze for the two clock-select pins.

While the freeze bit is clear, the clock-select outputs follow the synchronized pins. While it is set, they hold their values.

The bus is synchronous. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational and reflects the location on `bus_addr` and the current state. Reads have no side effects.

Top module: `cfg_idx_bank`

## Requirements
- R1: Writing location 0 loads the index register from the low IDX_W bits of the write data. Reading location 0 returns the index, zero-extended. The index resets to 0.
- R2: With index 0, the data window reads the revision constant REV (default 8'h2A). Writes there change nothing.
- R3: Writing 1 to bit 0 of entry 1 sets `test_mode_o`. The bit always reads 0. Writing 0 does not clear it. Only reset clears it.
- R4: Bit 1 of entry 1 (`selfprog_o`) is set by writing 1 and cleared by writing 0. A write of 1 takes effect only while the lock indicator is 0. In any cycle where the lock indicator is 1, the bit is 0.
- R5: Bit 2 of entry 1 (`lock_o`) reads the lock state. The lock state resets to 1. On each clock it becomes the inverse of `unlock_i` sampled at that edge. Writes do not change it.
- R6: Bit 3 of entry 1 always reads 0, even after a write of 1. Bits 7..6 also read 0.
- R7: Bit 4 of entry 1 is read/write, resets to 0, and drives `clk_out_dis_o`.
- R8: Bit 5 of entry 1 is read/write and resets to 0. While it is 0, `clk_sel_o` follows `clk_sel_pin` after two synchronizer stages and an output register, a latency of 3 clocks. From the edge at which the bit is written to 1, `clk_sel_o` holds its value whatever the pins do. After the bit is cleared, `clk_sel_o` follows the pins again.
- R9: An index other than 0 or 1 reads 0 through the data window. Writes through it change no entry or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index register, 1 = data window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed location |
| unlock_i | input | 1 | External unlock level, 1 = unlocked |
| clk_sel_pin | input | SEL_W | Raw clock-select pins |
| test_mode_o | output | 1 | Sticky test-mode level |
| selfprog_o | output | 1 | Self-programming enable |
| lock_o | output | 1 | Lock indicator |
| clk_out_dis_o | output | 1 | Clock-output disable |
| clk_sel_o | output | SEL_W | Synchronized clock select, or the frozen value |

## Verification
The assertions assume that `unlock_i` is a level that can be sampled at any edge. They also assume that `bus_addr`, `bus_we` and `bus_wdata` are stable whenever `bus_en` is high at an edge. The bench drives every input half a clock before the edge that samples it, and it holds each bus access for exactly one edge. `clk_sel_pin` may be asynchronous in use. The bench nevertheless changes it only at falling edges, so the 3-clock follow latency and the frozen value can be checked at exact cycles.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    localparam int BIT_TEST  = 0;
    localparam int BIT_SPE   = 1;
    localparam int BIT_LOCK  = 2;
    localparam int BIT_RSVD  = 3;
    localparam int BIT_CKDIS = 4;
    localparam int BIT_FRZ   = 5;
    localparam int CTL_BITS  = 6;

    typedef struct packed {
        logic test;
        logic spe;
        logic lock;
        logic ckdis;
        logic frz;
    } ctl_state_t;

endpackage

// File: rtl/cfg_ctrl_entry.sv
module cfg_ctrl_entry
    import cfg_bank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock_i,
    output ctl_state_t        state_q,
    output logic              frz_nxt,
    output logic [DATA_W-1:0] rd_val
);

    ctl_state_t state_d;

    logic unused_bits;
    assign unused_bits = ^{wdata[DATA_W-1:CTL_BITS], wdata[BIT_RSVD], wdata[BIT_LOCK]};

    always_comb begin
        state_d      = state_q;
        state_d.lock = ~unlock_i;
        if (wr_en) begin
            state_d.test  = state_q.test | wdata[BIT_TEST];
            state_d.spe   = wdata[BIT_SPE] & ~state_q.lock;
            state_d.ckdis = wdata[BIT_CKDIS];
            state_d.frz   = wdata[BIT_FRZ];
        end
        if (state_d.lock) begin
            state_d.spe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{test: 1'b0, spe: 1'b0, lock: 1'b1, ckdis: 1'b0, frz: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign frz_nxt = state_d.frz;

    always_comb begin
        rd_val            = '0;
        rd_val[BIT_SPE]   = state_q.spe;
        rd_val[BIT_LOCK]  = state_q.lock;
        rd_val[BIT_CKDIS] = state_q.ckdis;
        rd_val[BIT_FRZ]   = state_q.frz;
    end

    p_test_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.test |=> state_q.test);

    p_spe_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.lock |-> !state_q.spe);

    p_lock_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q.lock == !$past(unlock_i)));

endmodule

// File: rtl/cfg_clksel_hold.sv
module cfg_clksel_hold #(
    parameter int SEL_W  = 2,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] pins,
    input  logic             frz_nxt,
    input  logic             frz_q,
    output logic [SEL_W-1:0] sel_q
);

    typedef struct packed {
        logic [SYNC_N-1:0][SEL_W-1:0] chain;
        logic [SEL_W-1:0]             sel;
    } hold_t;

    hold_t cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.chain[0] = pins;
        for (int i = 1; i < SYNC_N; i++) begin
            nxt_d.chain[i] = cur_q.chain[i-1];
        end
        if (!frz_nxt) begin
            nxt_d.sel = cur_q.chain[SYNC_N-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sel_q = cur_q.sel;

    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frz_q |-> $stable(sel_q));

endmodule

// File: rtl/cfg_idx_bank.sv
module cfg_idx_bank
    import cfg_bank_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter int              IDX_W  = 4,
    parameter int              SEL_W  = 2,
    parameter int              SYNC_N = 2,
    parameter logic [DATA_W-1:0] REV  = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              unlock_i,
    input  logic [SEL_W-1:0]  clk_sel_pin,
    output logic              test_mode_o,
    output logic              selfprog_o,
    output logic              lock_o,
    output logic              clk_out_dis_o,
    output logic [SEL_W-1:0]  clk_sel_o
);

    localparam logic [IDX_W-1:0] IDX_REV = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_CTL = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } top_t;

    top_t top_q, top_d;

    logic              wr_idx, wr_ctl;
    ctl_state_t        ctl_q;
    logic              frz_nxt;
    logic [DATA_W-1:0] ctl_rd;

    assign wr_idx = bus_en & bus_we & ~bus_addr;
    assign wr_ctl = bus_en & bus_we & bus_addr & (top_q.idx == IDX_CTL);

    always_comb begin
        top_d = top_q;
        if (wr_idx) begin
            top_d.idx = bus_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    cfg_ctrl_entry #(.DATA_W(DATA_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ctl),
        .wdata    (bus_wdata),
        .unlock_i (unlock_i),
        .state_q  (ctl_q),
        .frz_nxt  (frz_nxt),
        .rd_val   (ctl_rd)
    );

    cfg_clksel_hold #(.SEL_W(SEL_W), .SYNC_N(SYNC_N)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (clk_sel_pin),
        .frz_nxt (frz_nxt),
        .frz_q   (ctl_q.frz),
        .sel_q   (clk_sel_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[IDX_W-1:0] = top_q.idx;
        end else if (top_q.idx == IDX_REV) begin
            bus_rdata = REV;
        end else if (top_q.idx == IDX_CTL) begin
            bus_rdata = ctl_rd;
        end
    end

    assign test_mode_o   = ctl_q.test;
    assign selfprog_o    = ctl_q.spe;
    assign lock_o        = ctl_q.lock;
    assign clk_out_dis_o = ctl_q.ckdis;

    p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx |=> (top_q.idx == $past(bus_wdata[IDX_W-1:0])));

    p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && top_q.idx == IDX_CTL) |-> !bus_rdata[BIT_RSVD]);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && top_q.idx != IDX_REV && top_q.idx != IDX_CTL) |-> (bus_rdata == '0));

endmodule

// File: tb/test_cfg_idx_bank.sv
module test_cfg_idx_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       unlock_i = 1'b0;
    logic [1:0] clk_sel_pin = 2'b00;
    logic       test_mode_o, selfprog_o, lock_o, clk_out_dis_o;
    logic [1:0] clk_sel_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cfg_idx_bank i_cfg_idx_bank (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .unlock_i(unlock_i), .clk_sel_pin(clk_sel_pin),
        .test_mode_o(test_mode_o), .selfprog_o(selfprog_o), .lock_o(lock_o),
        .clk_out_dis_o(clk_out_dis_o), .clk_sel_o(clk_sel_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk("R1 index reset", v, 8'h00);
        chk("R5 lock reset", {7'b0, lock_o}, 8'h01);
        chk("R3 R4 R7 outputs reset", {5'b0, test_mode_o, selfprog_o, clk_out_dis_o}, 8'h00);
        wr(1'b0, 8'h01);
        rd(1'b1, v); chk("R5 R7 R8 ctrl reset read", v, 8'h04);
    endtask

    task automatic t_index();
        logic [7:0] v;
        wr(1'b0, 8'hF9);
        rd(1'b0, v); chk("R1 index low bits", v, 8'h09);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R1 index zero", v, 8'h00);
    endtask

    task automatic t_revision();
        logic [7:0] v;
        wr(1'b0, 8'h00);
        rd(1'b1, v); chk("R2 revision", v, 8'h2A);
        wr(1'b1, 8'hFF);
        rd(1'b1, v); chk("R2 revision after write", v, 8'h2A);
        chk("R2 no side effect", {4'b0, test_mode_o, selfprog_o, clk_out_dis_o, 1'b0}, 8'h00);
    endtask

    task automatic t_test_mode();
        logic [7:0] v;
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h01);
        chk("R3 test set", {7'b0, test_mode_o}, 8'h01);
        rd(1'b1, v); chk("R3 test reads 0", v & 8'h01, 8'h00);
        wr(1'b1, 8'h00);
        chk("R3 test sticky", {7'b0, test_mode_o}, 8'h01);
    endtask

    task automatic t_selfprog();
        logic [7:0] v;
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h02);
        chk("R4 no set while locked", {7'b0, selfprog_o}, 8'h00);
        @(negedge clk); unlock_i = 1'b1;
        @(negedge clk);
        chk("R5 unlock follows", {7'b0, lock_o}, 8'h00);
        wr(1'b1, 8'h02);
        chk("R4 set while unlocked", {7'b0, selfprog_o}, 8'h01);
        rd(1'b1, v); chk("R4 readback", v & 8'h06, 8'h02);
        wr(1'b1, 8'h00);
        chk("R4 clear", {7'b0, selfprog_o}, 8'h00);
        wr(1'b1, 8'h02);
        @(negedge clk); unlock_i = 1'b0;
        @(negedge clk);
        chk("R4 forced off by lock", {7'b0, selfprog_o}, 8'h00);
        chk("R5 relock", {7'b0, lock_o}, 8'h01);
        wr(1'b1, 8'h04);
        chk("R5 write ignored", {7'b0, lock_o}, 8'h01);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hC8);
        rd(1'b1, v); chk("R6 reserved and upper bits read 0", v & 8'hC8, 8'h00);
    endtask

    task automatic t_clkdis();
        logic [7:0] v;
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h10);
        chk("R7 disable out", {7'b0, clk_out_dis_o}, 8'h01);
        rd(1'b1, v); chk("R7 readback", v & 8'h10, 8'h10);
        wr(1'b1, 8'h00);
        chk("R7 cleared", {7'b0, clk_out_dis_o}, 8'h00);
    endtask

    task automatic t_clksel();
        logic [7:0] v;
        wr(1'b0, 8'h01);
        @(negedge clk); clk_sel_pin = 2'b10;
        idle(2);
        chk("R8 latency not yet", {6'b0, clk_sel_o}, 8'h00);
        idle(1);
        chk("R8 follow after 3", {6'b0, clk_sel_o}, 8'h02);
        wr(1'b1, 8'h20);
        rd(1'b1, v); chk("R8 freeze readback", v & 8'h20, 8'h20);
        @(negedge clk); clk_sel_pin = 2'b01;
        idle(6);
        chk("R8 frozen", {6'b0, clk_sel_o}, 8'h02);
        wr(1'b1, 8'h00);
        idle(1);
        chk("R8 follows after release", {6'b0, clk_sel_o}, 8'h01);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(1'b0, 8'h07);
        rd(1'b1, v); chk("R9 unmapped reads 0", v, 8'h00);
        wr(1'b1, 8'h30);
        chk("R9 write ignored", {6'b0, clk_out_dis_o, selfprog_o}, 8'h00);
        wr(1'b0, 8'h01);
        rd(1'b1, v); chk("R9 ctrl unchanged", v & 8'h30, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_revision();
        t_test_mode();
        t_selfprog();
        t_reserved();
        t_clkdis();
        t_clksel();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule